// File: doc/BRIEF.md
# Picture-in-Picture Window Overlay Compositor

This block produces the display-side overlay of a picture-in-picture system. A raster position arrives every clock as a pixel column and a line number. The block moves a background origin by a coarse global offset, then places a main window and a sub window at their own offsets from that origin. For each pixel it makes one of three choices. It can send out picture luma read from memory. It can send out a fixed gray fill. Or it can leave the live background visible, which it signals by driving the fast-blank output low.

Register values are copied into shadow registers on the clock in which `field_start` is high. Window placement and mode therefore never change inside a field. The gray fill covers a window until that channel's update flag shows that fresh picture data has been written. A luma threshold lets dark picture pixels drop out, so bright content such as subtitles can be keyed over the live picture. Memory access, scaling and chroma are handled outside this block.

Top module: `pip_overlay`

## Requirements
- R1: `ov_luma` and `fast_blank` are registered. The result for the inputs present in cycle k appears after the clock edge that ends cycle k. While `rst_n` is low, both outputs are 0 and every shadowed setting is 0, so both channels are off.
- R2: Shadowed settings are loaded only on the edge at which `field_start` is 1, and they govern pixels from the next cycle on. Changes to the register inputs while `field_start` is 0 have no effect on the outputs.
- R3: The background origin is at column `4*bg_hoff` and line `2*bg_voff`. A window starts at column origin + `4*hoff` and line origin + `voff`. It covers `width` columns and `height` lines: the start is inside the window and start+size is outside.
- R4: A channel whose enable bit is 0 never raises `fast_blank` and never supplies luma for its own window area.
- R5: Where both enabled windows cover a pixel, the sub window (its update flag, its threshold result) decides the output.
- R6: When `fill_off` = 0 and the selected window's update flag is 0, the output is luma 77 (0x4D) with `fast_blank` = 1, whatever the threshold is.
- R7: When `fill_off` = 1, the selected window shows `pic_luma` whatever its update flag is.
- R8: When picture data is shown, `fast_blank` = 0 if `pic_luma` < 16*`luma_thr`, and 1 otherwise. `ov_luma` still carries `pic_luma`. A threshold of 0 never drops a pixel.
- R9: A pixel outside every enabled window gives `ov_luma` = 0 and `fast_blank` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Strobe that loads the shadow registers |
| pix_x | input | 10 | Current pixel column |
| line_y | input | 10 | Current line in the field |
| main_en | input | 1 | Main channel enable |
| sub_en | input | 1 | Sub channel enable |
| fill_off | input | 1 | 1 = always show memory; 0 = gray until updated |
| luma_thr | input | 4 | Key threshold in units of 16 luma codes |
| bg_hoff | input | 4 | Background column offset, units of 4 pixels |
| bg_voff | input | 4 | Background line offset, units of 2 lines |
| main_hoff | input | 8 | Main window column offset, units of 4 pixels |
| main_voff | input | 8 | Main window line offset, units of 1 line |
| main_width | input | 10 | Main window width in pixels |
| main_height | input | 10 | Main window height in lines |
| sub_hoff | input | 8 | Sub window column offset, units of 4 pixels |
| sub_voff | input | 8 | Sub window line offset, units of 1 line |
| sub_width | input | 10 | Sub window width in pixels |
| sub_height | input | 10 | Sub window height in lines |
| main_upd | input | 1 | Main channel has fresh data since the mode change |
| sub_upd | input | 1 | Sub channel has fresh data since the mode change |
| pic_luma | input | 8 | Stored luma for the current pixel |
| ov_luma | output | 8 | Overlay luma |
| fast_blank | output | 1 | 1 = overlay shown, 0 = live background |

## Verification
The hardest case to reach from the ports is one where the live register inputs and the shadowed copy disagree. Without that, any failure to hold settings for the whole field would go unseen. The stimulus moves the windows, the background and the enables while `field_start` stays low. It scans the old and the new window edges, which must still match the old placement, and then strobes `field_start` and scans again. The window edges are scanned column by column and line by line, one step either side of every boundary. The key threshold is driven exactly at 16*T-1 and 16*T.

// File: rtl/pip_pkg.sv
package pip_pkg;

  localparam int COORD_W     = 10;
  localparam int SZ_W        = 10;
  localparam int BG_FIELD_W  = 4;
  localparam int WIN_FIELD_W = 8;
  localparam int THR_W       = 4;
  localparam int LUMA_W      = 8;
  localparam int CALC_W      = COORD_W + 3;
  localparam int BG_H_STEP   = 4;
  localparam int BG_V_STEP   = 2;
  localparam int WIN_H_STEP  = 4;
  localparam int WIN_V_STEP  = 1;
  localparam int THR_STEP    = 16;
  localparam int NUM_CH      = 2;
  localparam int CH_MAIN     = 0;
  localparam int CH_SUB      = 1;
  localparam logic [LUMA_W-1:0] GRAY_LUMA = LUMA_W'(77);

  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_MAIN = 2'd1, SRC_SUB = 2'd2} src_e;

  typedef struct packed {
    logic                   en;
    logic [WIN_FIELD_W-1:0] hoff;
    logic [WIN_FIELD_W-1:0] voff;
    logic [SZ_W-1:0]        width;
    logic [SZ_W-1:0]        height;
  } win_cfg_t;

  typedef struct packed {
    logic                  fill_off;
    logic [THR_W-1:0]      thr;
    logic [BG_FIELD_W-1:0] bg_h;
    logic [BG_FIELD_W-1:0] bg_v;
    win_cfg_t              main_w;
    win_cfg_t              sub_w;
  } pip_cfg_t;

  // Coarse field scaled into the calculation width.
  function automatic logic [CALC_W-1:0] scale_off(input logic [WIN_FIELD_W-1:0] f,
                                                  input int unsigned step);
    return CALC_W'(f) * CALC_W'(step);
  endfunction

  // Window start = base + offset * step.
  function automatic logic [CALC_W-1:0] place(input logic [CALC_W-1:0] base,
                                              input logic [WIN_FIELD_W-1:0] off,
                                              input int unsigned step);
    return base + scale_off(off, step);
  endfunction

  // Half-open interval test [start, start+len).
  function automatic logic span_hit(input logic [COORD_W-1:0] c,
                                    input logic [CALC_W-1:0]  start,
                                    input logic [SZ_W-1:0]    len);
    logic [CALC_W-1:0] cc;
    cc = CALC_W'(c);
    return (cc >= start) && (cc < start + CALC_W'(len));
  endfunction

  // 1 when picture luma reaches the key threshold.
  function automatic logic key_keep(input logic [LUMA_W-1:0] luma,
                                    input logic [THR_W-1:0]  thr);
    return (LUMA_W+1)'(luma) >= ((LUMA_W+1)'(thr) * (LUMA_W+1)'(THR_STEP));
  endfunction

endpackage

// File: rtl/pip_cfg_shadow.sv
module pip_cfg_shadow
  import pip_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  pip_cfg_t cfg_live,
  output pip_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_live;
    end
  end

endmodule

// File: rtl/pip_win_hit.sv
module pip_win_hit
  import pip_pkg::*;
#(
  parameter int H_STEP = WIN_H_STEP,
  parameter int V_STEP = WIN_V_STEP
) (
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] line_y,
  input  logic [CALC_W-1:0]  base_x,
  input  logic [CALC_W-1:0]  base_y,
  input  win_cfg_t           win,
  output logic               hit
);

  logic [CALC_W-1:0] x0;
  logic [CALC_W-1:0] y0;
  logic              in_x;
  logic              in_y;

  always_comb begin
    x0   = place(base_x, win.hoff, H_STEP);
    y0   = place(base_y, win.voff, V_STEP);
    in_x = span_hit(pix_x, x0, win.width);
    in_y = span_hit(line_y, y0, win.height);
    hit  = in_x && in_y;
  end

endmodule

// File: rtl/pip_pixel_sel.sv
module pip_pixel_sel
  import pip_pkg::*;
(
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] en,
  input  logic [NUM_CH-1:0] upd,
  input  logic              fill_off,
  input  logic [THR_W-1:0]  thr,
  input  logic [LUMA_W-1:0] pic_luma,
  output src_e              src,
  output logic [LUMA_W-1:0] luma,
  output logic              fb,
  output logic              gray_evt,
  output logic              key_drop
);

  logic sel_sub;
  logic sel_main;
  logic upd_sel;

  always_comb begin
    sel_sub  = hit[CH_SUB] && en[CH_SUB];
    sel_main = hit[CH_MAIN] && en[CH_MAIN] && !sel_sub;
    upd_sel  = sel_sub ? upd[CH_SUB] : upd[CH_MAIN];
    src      = sel_sub ? SRC_SUB : (sel_main ? SRC_MAIN : SRC_NONE);
    luma     = '0;
    fb       = 1'b0;
    gray_evt = 1'b0;
    key_drop = 1'b0;
    if (src != SRC_NONE) begin
      if (!fill_off && !upd_sel) begin
        gray_evt = 1'b1;
        luma     = GRAY_LUMA;
        fb       = 1'b1;
      end else begin
        luma     = pic_luma;
        fb       = key_keep(pic_luma, thr);
        key_drop = !fb;
      end
    end
  end

endmodule

// File: rtl/pip_overlay.sv
module pip_overlay
  import pip_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   field_start,
  input  logic [COORD_W-1:0]     pix_x,
  input  logic [COORD_W-1:0]     line_y,
  input  logic                   main_en,
  input  logic                   sub_en,
  input  logic                   fill_off,
  input  logic [THR_W-1:0]       luma_thr,
  input  logic [BG_FIELD_W-1:0]  bg_hoff,
  input  logic [BG_FIELD_W-1:0]  bg_voff,
  input  logic [WIN_FIELD_W-1:0] main_hoff,
  input  logic [WIN_FIELD_W-1:0] main_voff,
  input  logic [SZ_W-1:0]        main_width,
  input  logic [SZ_W-1:0]        main_height,
  input  logic [WIN_FIELD_W-1:0] sub_hoff,
  input  logic [WIN_FIELD_W-1:0] sub_voff,
  input  logic [SZ_W-1:0]        sub_width,
  input  logic [SZ_W-1:0]        sub_height,
  input  logic                   main_upd,
  input  logic                   sub_upd,
  input  logic [LUMA_W-1:0]      pic_luma,
  output logic [LUMA_W-1:0]      ov_luma,
  output logic                   fast_blank
);

  pip_cfg_t          cfg_live;
  pip_cfg_t          cfg_q;
  win_cfg_t          win_q [NUM_CH];
  logic [CALC_W-1:0] base_x;
  logic [CALC_W-1:0] base_y;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] upd_vec;
  src_e              src_c;
  src_e              src_q;
  logic [LUMA_W-1:0] luma_c;
  logic              fb_c;
  logic              gray_evt;
  logic              key_drop;
  logic              sub_live;

  always_comb begin
    cfg_live.fill_off      = fill_off;
    cfg_live.thr           = luma_thr;
    cfg_live.bg_h          = bg_hoff;
    cfg_live.bg_v          = bg_voff;
    cfg_live.main_w.en     = main_en;
    cfg_live.main_w.hoff   = main_hoff;
    cfg_live.main_w.voff   = main_voff;
    cfg_live.main_w.width  = main_width;
    cfg_live.main_w.height = main_height;
    cfg_live.sub_w.en      = sub_en;
    cfg_live.sub_w.hoff    = sub_hoff;
    cfg_live.sub_w.voff    = sub_voff;
    cfg_live.sub_w.width   = sub_width;
    cfg_live.sub_w.height  = sub_height;
  end

  pip_cfg_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (field_start),
    .cfg_live (cfg_live),
    .cfg_q    (cfg_q)
  );

  always_comb begin
    base_x           = scale_off(WIN_FIELD_W'(cfg_q.bg_h), BG_H_STEP);
    base_y           = scale_off(WIN_FIELD_W'(cfg_q.bg_v), BG_V_STEP);
    win_q[CH_MAIN]   = cfg_q.main_w;
    win_q[CH_SUB]    = cfg_q.sub_w;
    upd_vec[CH_MAIN] = main_upd;
    upd_vec[CH_SUB]  = sub_upd;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_win
    pip_win_hit #(
      .H_STEP (WIN_H_STEP),
      .V_STEP (WIN_V_STEP)
    ) u_hit (
      .pix_x  (pix_x),
      .line_y (line_y),
      .base_x (base_x),
      .base_y (base_y),
      .win    (win_q[ch]),
      .hit    (hit[ch])
    );
    assign en_q[ch] = win_q[ch].en;
  end

  assign sub_live = hit[CH_SUB] && en_q[CH_SUB];

  pip_pixel_sel u_sel (
    .hit      (hit),
    .en       (en_q),
    .upd      (upd_vec),
    .fill_off (cfg_q.fill_off),
    .thr      (cfg_q.thr),
    .pic_luma (pic_luma),
    .src      (src_c),
    .luma     (luma_c),
    .fb       (fb_c),
    .gray_evt (gray_evt),
    .key_drop (key_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_luma    <= '0;
      fast_blank <= 1'b0;
      src_q      <= SRC_NONE;
    end else begin
      ov_luma    <= luma_c;
      fast_blank <= fb_c;
      src_q      <= src_c;
    end
  end

endmodule

// File: rtl/pip_overlay_chk.sv
module pip_overlay_chk
  import pip_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              field_start,
  input pip_cfg_t          cfg_q,
  input logic              gray_evt,
  input logic              key_drop,
  input logic              sub_live,
  input src_e              src_q,
  input logic [LUMA_W-1:0] ov_luma,
  input logic              fast_blank
);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(field_start) |-> $stable(cfg_q));

  assert_off_no_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.main_w.en && !cfg_q.sub_w.en) |=> !fast_blank);

  assert_sub_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_live |=> (src_q == SRC_SUB));

  assert_gray_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gray_evt |=> (fast_blank && ov_luma == GRAY_LUMA));

  assert_key_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_drop |=> !fast_blank);

  assert_outside_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_NONE) |-> (!fast_blank && ov_luma == '0));

endmodule

bind pip_overlay pip_overlay_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .field_start (field_start),
  .cfg_q       (cfg_q),
  .gray_evt    (gray_evt),
  .key_drop    (key_drop),
  .sub_live    (sub_live),
  .src_q       (src_q),
  .ov_luma     (ov_luma),
  .fast_blank  (fast_blank)
);

// File: tb/pip_overlay_tb.sv
module pip_overlay_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       field_start = 1'b0;
  logic [9:0] pix_x = '0, line_y = '0;
  logic       main_en = 1'b0, sub_en = 1'b0, fill_off = 1'b1;
  logic [3:0] luma_thr = '0, bg_hoff = '0, bg_voff = '0;
  logic [7:0] main_hoff = '0, main_voff = '0, sub_hoff = '0, sub_voff = '0;
  logic [9:0] main_width = '0, main_height = '0, sub_width = '0, sub_height = '0;
  logic       main_upd = 1'b0, sub_upd = 1'b0;
  logic [7:0] pic_luma = '0;
  logic [7:0] ov_luma;
  logic       fast_blank;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state: shadowed settings as plain integers.
  int s_men, s_sen, s_foff, s_thr, s_bgh, s_bgv;
  int s_mh, s_mv, s_mw, s_mht, s_sh, s_sv, s_sw, s_sht;
  int exp_luma, exp_fb;

  always #2.5 clk = ~clk;

  pip_overlay u_dut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .pix_x(pix_x), .line_y(line_y),
    .main_en(main_en), .sub_en(sub_en), .fill_off(fill_off), .luma_thr(luma_thr),
    .bg_hoff(bg_hoff), .bg_voff(bg_voff),
    .main_hoff(main_hoff), .main_voff(main_voff),
    .main_width(main_width), .main_height(main_height),
    .sub_hoff(sub_hoff), .sub_voff(sub_voff),
    .sub_width(sub_width), .sub_height(sub_height),
    .main_upd(main_upd), .sub_upd(sub_upd), .pic_luma(pic_luma),
    .ov_luma(ov_luma), .fast_blank(fast_blank)
  );

  function automatic bit inside_win(int x, int y, int hoff, int voff, int w, int h);
    int left, top;
    left = 4 * s_bgh + 4 * hoff;
    top  = 2 * s_bgv + voff;
    return (x >= left) && (x - left < w) && (y >= top) && (y - top < h);
  endfunction

  task automatic model_edge();
    int x, y, upd;
    bit in_s, in_m;
    x = int'(pix_x);
    y = int'(line_y);
    in_s = (s_sen != 0) && inside_win(x, y, s_sh, s_sv, s_sw, s_sht);
    in_m = (s_men != 0) && inside_win(x, y, s_mh, s_mv, s_mw, s_mht);
    exp_luma = 0;
    exp_fb   = 0;
    if (in_s || in_m) begin
      upd = in_s ? int'(sub_upd) : int'(main_upd);
      if (s_foff == 0 && upd == 0) begin
        exp_luma = 77;
        exp_fb   = 1;
      end else begin
        exp_luma = int'(pic_luma);
        exp_fb   = (int'(pic_luma) < 16 * s_thr) ? 0 : 1;
      end
    end
    if (field_start) begin
      s_men = main_en;  s_sen = sub_en;  s_foff = fill_off; s_thr = luma_thr;
      s_bgh = bg_hoff;  s_bgv = bg_voff;
      s_mh = main_hoff; s_mv = main_voff; s_mw = main_width; s_mht = main_height;
      s_sh = sub_hoff;  s_sv = sub_voff;  s_sw = sub_width;  s_sht = sub_height;
    end
  endtask

  task automatic compare(string tag);
    n_checks++;
    if (int'(ov_luma) != exp_luma || int'(fast_blank) != exp_fb) begin
      n_fails++;
      $display("FAIL %s x=%0d y=%0d: luma=%0d fb=%0d expected luma=%0d fb=%0d",
               tag, pix_x, line_y, ov_luma, fast_blank, exp_luma, exp_fb);
    end
  endtask

  // One pixel: inputs already driven, model at the edge, compare at negedge.
  task automatic tick(string tag);
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic pix(int x, int y, string tag);
    pix_x    = 10'(x);
    line_y   = 10'(y);
    pic_luma = 8'((x * 7 + y * 13) | 8'h80);
    tick(tag);
  endtask

  task automatic strobe();
    field_start = 1'b1;
    pix(0, 0, "R2");
    field_start = 1'b0;
  endtask

  // Scan a box around a window start/end, one step outside each edge.
  task automatic scan_box(int left, int top, int w, int h, string tag);
    for (int y = top - 1; y <= top + h; y += (h + 1) / 2)
      for (int x = left - 2; x <= left + w + 1; x++)
        pix(x, y, tag);
    for (int y = top - 2; y <= top + h + 1; y++)
      pix(left, y, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    s_men = 0; s_sen = 0; s_foff = 0; s_thr = 0; s_bgh = 0; s_bgv = 0;
    s_mh = 0; s_mv = 0; s_mw = 0; s_mht = 0; s_sh = 0; s_sv = 0; s_sw = 0; s_sht = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    exp_luma = 0; exp_fb = 0;
    compare("R1 reset");
    main_en = 1'b1; field_start = 1'b1;
    @(negedge clk);
    compare("R1 reset held");
    field_start = 1'b0;
    rst_n = 1'b1;
    pix(20, 20, "R1 shadow cleared");

    // R3: geometry with background offset
    main_en = 1'b1; fill_off = 1'b1; main_upd = 1'b1;
    bg_hoff = 4'd2; bg_voff = 4'd3;
    main_hoff = 8'd5; main_voff = 8'd4; main_width = 10'd16; main_height = 10'd6;
    strobe();
    scan_box(8 + 20, 6 + 4, 16, 6, "R3");

    // R2: move everything without the strobe; old placement must hold
    bg_hoff = 4'd0; bg_voff = 4'd0; main_hoff = 8'd40; main_voff = 8'd30;
    main_en = 1'b0; luma_thr = 4'd15;
    scan_box(28, 10, 16, 6, "R2 held");
    pix(160, 30, "R2 held new spot");
    main_en = 1'b1; luma_thr = 4'd0;
    strobe();
    scan_box(160, 30, 16, 6, "R2 applied");

    // R5: overlapping sub window wins
    sub_en = 1'b1; sub_upd = 1'b0; main_upd = 1'b1; fill_off = 1'b0;
    sub_hoff = 8'd42; sub_voff = 8'd32; sub_width = 10'd8; sub_height = 10'd3;
    strobe();
    scan_box(168, 32, 8, 3, "R5");

    // R6: gray fill, not keyed even with top threshold
    luma_thr = 4'd15;
    strobe();
    pix(170, 33, "R6 sub gray");
    main_upd = 1'b0;
    pix(162, 31, "R6 main gray");
    main_upd = 1'b1;
    pix(162, 31, "R6 main updated");

    // R7: fill disabled shows memory regardless of update flag
    fill_off = 1'b1; luma_thr = 4'd0; main_upd = 1'b0;
    strobe();
    pix(170, 33, "R7 sub");
    pix(162, 31, "R7 main");

    // R8: key threshold boundary
    luma_thr = 4'd5;
    strobe();
    pix_x = 10'd162; line_y = 10'd31;
    pic_luma = 8'd79; tick("R8 below");
    pic_luma = 8'd80; tick("R8 at");
    pic_luma = 8'd0;  tick("R8 zero");
    luma_thr = 4'd0;
    strobe();
    pix_x = 10'd162; line_y = 10'd31;
    pic_luma = 8'd0; tick("R8 thr zero");

    // R4: disabled channels
    main_en = 1'b0;
    strobe();
    scan_box(160, 30, 16, 6, "R4 main off");
    sub_en = 1'b0; main_en = 1'b1;
    strobe();
    pix(170, 33, "R4 sub off");
    main_en = 1'b0;
    strobe();
    pix(170, 33, "R4 both off");

    // R9: far outside
    main_en = 1'b1; sub_en = 1'b1;
    strobe();
    pix(1000, 500, "R9");
    pix(0, 0, "R9");

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule